// File: doc/BRIEF.md
# Programmable Edge Timing Generator

This block places timing edges for a tester channel. Each vector period may arm one edge. The armed delay is a 10-bit value: the upper two bits count whole master-clock cycles and the lower eight bits give a sub-cycle fine code of 1/256 of a cycle. A global 8-bit offset, common to all edges, is added to every delay before it is split. Carries from the fine part pass into the coarse part.

A pending edge counts its coarse cycles down. When the count expires, the block raises a one-cycle fire strobe and presents the fine code beside it, for a downstream vernier to use.

Delays reach up to four periods, so as many as four edges can be in flight at once. When several edges expire in the same cycle, they share one strobe. The block then reports an error if any of them sits closer than the refire limit to the earliest one.

Top module: `edge_timing_gen`

## Requirements
- R1: After reset, and after a reset that arrives while an edge is pending, `fire_o`, `fine_o`, `err_o` and `ovf_o` are 0 and no edge fires until a new arm.
- R2: The total delay is `delay_i + offset_i`. Its coarse part is total bits [9:8] and its fine part is bits [7:0]. For an arm sampled at clock edge k with coarse part C, `fire_o` is high during the cycle after edge k+1+C.
- R3: If `delay_i + offset_i` exceeds 1023, the total saturates to 1023 (coarse 3, fine 255). `ovf_o` is then high for the one cycle after the arming edge. A total of exactly 1023 does not set `ovf_o`.
- R4: While `fire_o` is high, `fine_o` carries the fine part of the firing edge's total delay.
- R5: Arms on consecutive cycles keep separate counters. Each fires at its own time, even when later arms are issued before earlier ones fire.
- R6: When two or more edges expire in the same cycle, `fire_o` is raised once and `fine_o` carries the smallest of their fine codes.
- R7: `err_o` is high with `fire_o` exactly when another edge expiring in that cycle has a fine code less than 64 steps above the smallest one. Equal codes count as a clash. A separation of exactly 64 does not.
- R8: While `fire_o` is low, `fine_o` is 0 and `err_o` is 0.
- R9: With `period_start_i` low, no edge is armed and `offset_i` and `delay_i` have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; one coarse step per cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| period_start_i | input | 1 | Arms one edge with the current delay and offset |
| delay_i | input | 10 | Programmed delay, {coarse[1:0], fine[7:0]} |
| offset_i | input | 8 | Global offset in fine steps, added to every delay |
| fire_o | output | 1 | One-cycle edge fire strobe |
| fine_o | output | 8 | Fine code for the vernier, valid with fire_o |
| err_o | output | 1 | Refire clash among coincident edges |
| ovf_o | output | 1 | Saturation of the summed delay |

## Verification
The assertions check the following on every cycle:
- an error never appears without a fire strobe;
- the fine code is zero when nothing fires;
- overflow only follows an arming cycle;
- no strobe appears more than four cycles after the most recent arm.

Only the bench scenarios can show the exact firing cycle, the carry of the offset into the coarse count, the saturation boundary at 1023 and the choice of the smallest coincident fine code. The same holds for the 63/64 step refire threshold and for discarding an edge that was pending when reset arrived.

// File: rtl/etg_pkg.sv
package etg_pkg;
    localparam int FINE_W_DEF   = 8;
    localparam int COARSE_W_DEF = 2;
    localparam int OFS_W_DEF    = 8;
    localparam int REFIRE_DEF   = 64;

    typedef struct packed {
        logic fire;
        logic err;
        logic ovf;
    } etg_flags_t;
endpackage

// File: rtl/etg_delay_sum.sv
module etg_delay_sum #(
    parameter int FINE_W   = 8,
    parameter int COARSE_W = 2,
    parameter int OFS_W    = 8
) (
    input  logic [COARSE_W+FINE_W-1:0] delay_i,
    input  logic [OFS_W-1:0]           offset_i,
    output logic [COARSE_W+FINE_W-1:0] total_o,
    output logic                       ovf_o
);
    localparam int DW = COARSE_W + FINE_W;

    logic [DW:0] raw;

    always_comb begin
        raw     = {1'b0, delay_i} + {{(DW + 1 - OFS_W){1'b0}}, offset_i};
        ovf_o   = raw[DW];
        total_o = raw[DW] ? {DW{1'b1}} : raw[DW-1:0];
    end
endmodule

// File: rtl/etg_slot.sv
module etg_slot #(
    parameter int FINE_W   = 8,
    parameter int COARSE_W = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [COARSE_W-1:0] coarse_i,
    input  logic [FINE_W-1:0]   fine_i,
    output logic                expire_o,
    output logic [FINE_W-1:0]   fine_o
);
    typedef struct packed {
        logic                active;
        logic [COARSE_W-1:0] cnt;
        logic [FINE_W-1:0]   fine;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d   = slot_q;
        expire_o = slot_q.active && (slot_q.cnt == '0);
        if (expire_o) begin
            slot_d.active = 1'b0;
        end else if (slot_q.active) begin
            slot_d.cnt = slot_q.cnt - 1'b1;
        end
        if (load_i) begin
            slot_d.active = 1'b1;
            slot_d.cnt    = coarse_i;
            slot_d.fine   = fine_i;
        end
        fine_o = slot_q.fine;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end
endmodule

// File: rtl/etg_fire_merge.sv
module etg_fire_merge #(
    parameter int SLOTS  = 4,
    parameter int FINE_W = 8,
    parameter int REFIRE = 64
) (
    input  logic [SLOTS-1:0]             expire_i,
    input  logic [SLOTS-1:0][FINE_W-1:0] fine_i,
    output logic                         any_o,
    output logic [FINE_W-1:0]            fine_min_o,
    output logic                         clash_o
);
    localparam logic [FINE_W-1:0] LIMIT = FINE_W'(REFIRE);
    localparam int                IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    logic [IDX_W-1:0] min_idx;

    always_comb begin
        any_o      = |expire_i;
        fine_min_o = '1;
        min_idx    = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (expire_i[i] && (fine_i[i] < fine_min_o || (fine_i[i] == fine_min_o && !(|(expire_i & ((SLOTS'(1) << i) - 1'b1)))))) begin
                fine_min_o = fine_i[i];
                min_idx    = IDX_W'(i);
            end
        end
        if (!any_o) begin
            fine_min_o = '0;
        end
        clash_o = 1'b0;
        for (int j = 0; j < SLOTS; j++) begin
            if (expire_i[j] && (IDX_W'(j) != min_idx) && ((fine_i[j] - fine_min_o) < LIMIT)) begin
                clash_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/edge_timing_gen.sv
module edge_timing_gen
    import etg_pkg::*;
#(
    parameter int FINE_W   = FINE_W_DEF,
    parameter int COARSE_W = COARSE_W_DEF,
    parameter int OFS_W    = OFS_W_DEF,
    parameter int REFIRE   = REFIRE_DEF
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       period_start_i,
    input  logic [COARSE_W+FINE_W-1:0] delay_i,
    input  logic [OFS_W-1:0]           offset_i,
    output logic                       fire_o,
    output logic [FINE_W-1:0]          fine_o,
    output logic                       err_o,
    output logic                       ovf_o
);
    localparam int DW    = COARSE_W + FINE_W;
    localparam int SLOTS = 2 ** COARSE_W;

    typedef struct packed {
        logic [COARSE_W-1:0] ptr;
        logic [FINE_W-1:0]   fine;
        etg_flags_t          flags;
    } top_t;

    top_t top_d, top_q;

    logic [DW-1:0]                total;
    logic                         sum_ovf;
    logic [SLOTS-1:0]             load;
    logic [SLOTS-1:0]             expire;
    logic [SLOTS-1:0][FINE_W-1:0] slot_fine;
    logic                         any_fire;
    logic [FINE_W-1:0]            fine_min;
    logic                         clash;

    etg_delay_sum #(.FINE_W(FINE_W), .COARSE_W(COARSE_W), .OFS_W(OFS_W)) u_sum (
        .delay_i  (delay_i),
        .offset_i (offset_i),
        .total_o  (total),
        .ovf_o    (sum_ovf)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign load[g] = period_start_i && (top_q.ptr == COARSE_W'(g));
        etg_slot #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_slot (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .load_i   (load[g]),
            .coarse_i (total[DW-1:FINE_W]),
            .fine_i   (total[FINE_W-1:0]),
            .expire_o (expire[g]),
            .fine_o   (slot_fine[g])
        );
    end

    etg_fire_merge #(.SLOTS(SLOTS), .FINE_W(FINE_W), .REFIRE(REFIRE)) u_merge (
        .expire_i   (expire),
        .fine_i     (slot_fine),
        .any_o      (any_fire),
        .fine_min_o (fine_min),
        .clash_o    (clash)
    );

    always_comb begin
        top_d            = top_q;
        top_d.ptr        = period_start_i ? top_q.ptr + 1'b1 : top_q.ptr;
        top_d.flags.fire = any_fire;
        top_d.fine       = any_fire ? fine_min : '0;
        top_d.flags.err  = any_fire && clash;
        top_d.flags.ovf  = period_start_i && sum_ovf;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign fire_o = top_q.flags.fire;
    assign fine_o = top_q.fine;
    assign err_o  = top_q.flags.err;
    assign ovf_o  = top_q.flags.ovf;
endmodule

// File: rtl/edge_timing_gen_chk.sv
module edge_timing_gen_chk #(
    parameter int FINE_W   = 8,
    parameter int COARSE_W = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              period_start_i,
    input logic              fire_o,
    input logic [FINE_W-1:0] fine_o,
    input logic              err_o,
    input logic              ovf_o
);
    localparam int SLOTS = 2 ** COARSE_W;
    localparam logic [7:0] CAP = 8'(SLOTS + 1);

    logic [7:0] since_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            since_q <= CAP;
        end else if (period_start_i) begin
            since_q <= '0;
        end else if (since_q != CAP) begin
            since_q <= since_q + 1'b1;
        end
    end

    p_err_needs_fire_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> fire_o);

    p_fine_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fire_o |-> (fine_o == '0 && !err_o));

    p_ovf_after_arm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> $past(period_start_i));

    p_fire_armed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |-> (since_q <= 8'(SLOTS)));
endmodule

bind edge_timing_gen edge_timing_gen_chk #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .period_start_i (period_start_i),
    .fire_o         (fire_o),
    .fine_o         (fine_o),
    .err_o          (err_o),
    .ovf_o          (ovf_o)
);

// File: tb/test_edge_timing_gen.sv
module test_edge_timing_gen;
    localparam int NCYC = 3000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ps;
    logic [9:0] dly;
    logic [7:0] ofs;
    logic       fire;
    logic [7:0] fine;
    logic       err;
    logic       ovf;

    int         cnt_m [NCYC];
    logic [7:0] fq_m  [NCYC][4];
    bit         ovf_m [NCYC];
    int         checks = 0;
    int         fails  = 0;
    int         e      = -1;
    string      ftag   = "R2";

    always #2 clk = ~clk;

    edge_timing_gen i_edge_timing_gen (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .period_start_i (ps),
        .delay_i        (dly),
        .offset_i       (ofs),
        .fire_o         (fire),
        .fine_o         (fine),
        .err_o          (err),
        .ovf_o          (ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, e, act, exp);
        end
    endtask

    function automatic void arm(input int a, input logic [9:0] d, input logic [7:0] o);
        int s = int'(d) + int'(o);
        int t;
        if (s > 1023) begin
            s = 1023;
            ovf_m[a] = 1'b1;
        end
        t = a + 1 + (s >> 8);
        if (t < NCYC && cnt_m[t] < 4) begin
            fq_m[t][cnt_m[t]] = 8'(s & 255);
            cnt_m[t]++;
        end
    endfunction

    task automatic verify(input int i);
        int  mn = 256;
        int  mi = 0;
        bit  cl = 1'b0;
        bit  xf = cnt_m[i] > 0;
        for (int k = 0; k < cnt_m[i]; k++) begin
            if (int'(fq_m[i][k]) < mn) begin
                mn = int'(fq_m[i][k]);
                mi = k;
            end
        end
        for (int k = 0; k < cnt_m[i]; k++) begin
            if (k != mi && int'(fq_m[i][k]) - mn < 64) cl = 1'b1;
        end
        chk(fire == xf, ftag, int'(fire), int'(xf));
        if (xf) begin
            chk(int'(fine) == mn, (cnt_m[i] > 1) ? "R6" : "R4", int'(fine), mn);
            chk(err == cl, "R7", int'(err), int'(cl));
        end else begin
            chk(fine == 8'd0, "R8", int'(fine), 0);
            chk(err == 1'b0, "R8", int'(err), 0);
        end
        chk(ovf == ovf_m[i], "R3", int'(ovf), int'(ovf_m[i]));
    endtask

    task automatic tick(input bit p, input logic [9:0] d, input logic [7:0] o);
        ps  = p;
        dly = d;
        ofs = o;
        if (p) arm(e + 1, d, o);
        @(posedge clk);
        e++;
        @(negedge clk);
        verify(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(1'b0, 10'd0, 8'd0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCYC; i++) begin
            cnt_m[i] = 0;
            ovf_m[i] = 1'b0;
        end
        void'($urandom(32'd2207));
        rst_n = 1'b0;
        ps    = 1'b0;
        dly   = '0;
        ofs   = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs at reset
        chk({fire, fine, err, ovf} == 11'd0, "R1", int'({fire, fine, err, ovf}), 0);
        rst_n = 1'b1;
        // R1: arm an edge, then reset before it fires
        ps  = 1'b1;
        dly = {2'd3, 8'd5};
        @(posedge clk);
        @(negedge clk);
        ps    = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({fire, fine, err, ovf} == 11'd0, "R1", int'({fire, fine, err, ovf}), 0);
        rst_n = 1'b1;
        ftag  = "R1";
        idle(6);

        // R2 / R4: each coarse value, with and without offset
        ftag = "R2";
        for (int c = 0; c < 4; c++) begin
            tick(1'b1, {2'(c), 8'd17}, 8'd0);
            idle(6);
        end
        tick(1'b1, {2'd0, 8'd240}, 8'd32);   // carry into coarse: total 0x110
        idle(6);
        tick(1'b1, {2'd2, 8'd200}, 8'd100);  // total 0x32C
        idle(6);

        // R3: saturation boundary
        tick(1'b1, 10'd1023, 8'd0);
        idle(6);
        tick(1'b1, 10'd1023, 8'd1);
        idle(6);
        tick(1'b1, 10'd1000, 8'd200);
        idle(6);

        // R5: back-to-back long arms
        ftag = "R5";
        for (int k = 0; k < 6; k++) tick(1'b1, {2'd3, 8'(k * 40)}, 8'd0);
        idle(6);
        ftag = "R2";

        // R6 / R7: coincident expiries
        tick(1'b1, {2'd1, 8'd10}, 8'd0); tick(1'b1, {2'd0, 8'd100}, 8'd0); idle(5);
        tick(1'b1, {2'd1, 8'd10}, 8'd0); tick(1'b1, {2'd0, 8'd60},  8'd0); idle(5);
        tick(1'b1, {2'd1, 8'd10}, 8'd0); tick(1'b1, {2'd0, 8'd74},  8'd0); idle(5);
        tick(1'b1, {2'd1, 8'd10}, 8'd0); tick(1'b1, {2'd0, 8'd73},  8'd0); idle(5);
        tick(1'b1, {2'd1, 8'd30}, 8'd0); tick(1'b1, {2'd0, 8'd30},  8'd0); idle(5);
        tick(1'b1, {2'd3, 8'd200}, 8'd0);
        tick(1'b1, {2'd2, 8'd150}, 8'd0);
        tick(1'b1, {2'd1, 8'd100}, 8'd0);
        tick(1'b1, {2'd0, 8'd90},  8'd0);
        idle(6);

        // R9: no arm, inputs wiggle
        ftag = "R9";
        for (int k = 0; k < 20; k++) tick(1'b0, 10'($urandom), 8'($urandom));
        ftag = "R2";

        // random mix
        begin
            logic [7:0] o = 8'd0;
            for (int k = 0; k < 2000; k++) begin
                if ($urandom_range(0, 31) == 0) o = 8'($urandom);
                tick(1'($urandom_range(0, 1)), 10'($urandom), o);
            end
        end
        idle(8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule